// File: doc/BRIEF.md
# One-Wire Bit-Slot Write Engine

This block shifts a word of one or more bytes out onto a single open-drain one-wire bus, least significant bit first. Each bit occupies a fixed time slot built from a microsecond tick. The tick comes from dividing the system clock. A slot has three phases. The line is pulled low for 6 ticks. For a 1 the line is then released. For a 0 it is held low until tick 66. A 10-tick recovery interval with the line released closes the slot, which is 76 ticks long in total.

The output `drive_low` is active high and controls an external pull-down. The engine never drives the bus high. A `hold` input lets the surrounding system stretch the gap between any two bits, because the protocol permits an arbitrary pause there.

The controller is an enumerated state machine with these states:
- `ST_IDLE`: waiting for `start`.
- `ST_LOW`: opening low phase.
- `ST_DATA`: data phase, in which the line level is the current bit.
- `ST_RECOVER`: recovery gap.
- `ST_GAP`: held pause between bits.
- `ST_FIN`: a one-cycle completion state.

Its transitions are:
- start accepted: `ST_IDLE`/`ST_FIN` to `ST_LOW`, or to `ST_FIN` when there are no bits.
- low phase over: `ST_LOW` to `ST_DATA`.
- release: `ST_DATA` to `ST_RECOVER`.
- next bit: `ST_RECOVER` to `ST_LOW`.
- pause: `ST_RECOVER` to `ST_GAP`.
- resume: `ST_GAP` to `ST_LOW`.
- last bit: `ST_RECOVER` to `ST_FIN`.
- retire: `ST_FIN` to `ST_IDLE`.

Top module: `ow_bit_writer`

## Requirements
- R1: After reset, `drive_low`, `busy` and `done` are all 0.
- R2: A `start` seen at a rising edge while the engine is not busy captures `data` and `byte_cnt`. The engine then sends 8 × `byte_cnt` bits of `data`, starting from bit 0 and moving upward.
- R3: Each slot begins with `drive_low` high for exactly 6 ticks. The first slot begins in the cycle after the edge that accepted `start`.
- R4: After the first 6 ticks of a slot, a 1 bit releases the line (`drive_low` = 0). A 0 bit keeps `drive_low` high until 66 ticks after the slot began.
- R5: Ticks 66 to 75 of each slot are a recovery gap with `drive_low` = 0. When `hold` is low at the slot's last cycle, the next slot starts immediately after tick 76.
- R6: One tick is `TICK_DIV` clock cycles (15 by default). The divider restarts at every slot start. With the defaults, a 1 bit gives a low pulse of 90 cycles, a 0 bit gives 990 cycles, and a slot lasts 1140 cycles.
- R7: When `hold` is high at the last cycle of a non-final slot, the engine waits with `busy` = 1 and `drive_low` = 0. It starts a fresh slot in the cycle after an edge at which `hold` is low.
- R8: `busy` is 1 from the cycle after the accepting edge until the final slot's recovery ends.
- R9: `done` is 1 for exactly one cycle, directly after the final slot's recovery, with `busy` = 0 in that cycle.
- R10: A `start` while `busy` is 1 is ignored. The ongoing bit stream and its timing are unchanged.
- R11: A `byte_cnt` of 0 sends no slot and gives `done` in the cycle after acceptance. A `byte_cnt` larger than `DATA_W`/8 is treated as `DATA_W`/8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (15 MHz nominal for a 1 µs tick) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (single-cycle pulse) |
| byte_cnt | input | 2 | Number of bytes to send |
| data | input | 16 | Word to send, least significant bit first |
| hold | input | 1 | Pause before the next bit while high |
| drive_low | output | 1 | 1 pulls the bus low, 0 releases it |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `start` arrives as a clean synchronous pulse and that `hold` is synchronous to `clk`. The divider assertion also assumes a `TICK_DIV` of at least 2. Inside the engine, they assume that the slot counter is restarted at every slot start, so it never passes the 76-tick slot length. The stimulus drives every input on the falling clock edge, uses the default divider, and sends `start` pulses both in idle and during a running transfer. It raises and lowers `hold` only while a transfer is running.

// File: rtl/owsw_pkg.sv
package owsw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOW     = 3'd1,
        ST_DATA    = 3'd2,
        ST_RECOVER = 3'd3,
        ST_GAP     = 3'd4,
        ST_FIN     = 3'd5
    } owsw_state_e;
endpackage

// File: rtl/owsw_tick_gen.sv
module owsw_tick_gen #(
    parameter int TICK_DIV = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_cnt;

    assign tick = run && (div_cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (clr) begin
            div_cnt <= '0;
        end else if (run) begin
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
        end
    end

    generate
        if (TICK_DIV > 1) begin : g_chk
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R6
        end
    endgenerate
endmodule

// File: rtl/owsw_slot_timer.sv
module owsw_slot_timer #(
    parameter int T_LOW  = 6,
    parameter int T_DATA = 60,
    parameter int T_REC  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic low_end,
    output logic data_end,
    output logic slot_end
);
    localparam int T_RELEASE = T_LOW + T_DATA;
    localparam int T_SLOT    = T_RELEASE + T_REC;
    localparam int TW        = $clog2(T_SLOT + 1);

    logic [TW-1:0] tick_cnt;

    assign low_end  = tick && (tick_cnt == TW'(T_LOW - 1));
    assign data_end = tick && (tick_cnt == TW'(T_RELEASE - 1));
    assign slot_end = tick && (tick_cnt == TW'(T_SLOT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (clr || slot_end) begin
            tick_cnt <= '0;
        end else if (tick) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt < TW'(T_SLOT)); // R5
endmodule

// File: rtl/ow_bit_writer.sv
module ow_bit_writer
    import owsw_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int TICK_DIV = 15,
    parameter int T_LOW    = 6,
    parameter int T_DATA   = 60,
    parameter int T_REC    = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  byte_cnt,
    input  logic [15:0] data,
    input  logic        hold,
    output logic        drive_low,
    output logic        busy,
    output logic        done
);
    localparam int MAX_BYTES = DATA_W / 8;
    localparam int BW        = $clog2(DATA_W + 1);

    owsw_state_e   state, nxt;
    logic [DATA_W-1:0] shreg;
    logic [BW-1:0]     bits_left;
    logic [BW-1:0]     load_bits;
    logic              run, slot_go, tick;
    logic              low_end, data_end, slot_end;
    logic              last_bit, accept;

    always_comb begin
        if (int'(byte_cnt) > MAX_BYTES) load_bits = BW'(MAX_BYTES * 8);
        else                            load_bits = BW'(int'(byte_cnt) * 8);
    end

    assign accept   = start && ((state == ST_IDLE) || (state == ST_FIN));
    assign last_bit = (bits_left == BW'(1));
    assign run      = (state == ST_LOW) || (state == ST_DATA) || (state == ST_RECOVER);
    assign slot_go  = (nxt == ST_LOW) && (state != ST_LOW);

    owsw_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
        .clk(clk), .rst_n(rst_n), .clr(slot_go), .run(run), .tick(tick)
    );

    owsw_slot_timer #(.T_LOW(T_LOW), .T_DATA(T_DATA), .T_REC(T_REC)) i_slot (
        .clk(clk), .rst_n(rst_n), .clr(slot_go), .tick(tick),
        .low_end(low_end), .data_end(data_end), .slot_end(slot_end)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_FIN: begin
                if (accept) nxt = (load_bits == '0) ? ST_FIN : ST_LOW;
                else        nxt = ST_IDLE;
            end
            ST_LOW:     if (low_end)  nxt = ST_DATA;
            ST_DATA:    if (data_end) nxt = ST_RECOVER;
            ST_RECOVER: begin
                if (slot_end) begin
                    if (last_bit)  nxt = ST_FIN;
                    else if (hold) nxt = ST_GAP;
                    else           nxt = ST_LOW;
                end
            end
            ST_GAP:     if (!hold) nxt = ST_LOW;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // bit datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
        end else if (accept) begin
            shreg     <= DATA_W'(data);
            bits_left <= load_bits;
        end else if ((state == ST_RECOVER) && slot_end) begin
            shreg     <= shreg >> 1;
            bits_left <= bits_left - 1'b1;
        end
    end

    // outputs
    always_comb begin
        drive_low = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_LOW:     begin drive_low = 1'b1;       busy = 1'b1; end
            ST_DATA:    begin drive_low = ~shreg[0];  busy = 1'b1; end
            ST_RECOVER: busy = 1'b1;
            ST_GAP:     busy = 1'b1;
            ST_FIN:     done = 1'b1;
            default:    ;
        endcase
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R9
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !drive_low); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !slot_end |=> shreg == $past(shreg)); // R10
    AST_GAP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> (!drive_low && busy)); // R7
    AST_SLOT_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        slot_go |=> drive_low); // R3
endmodule

// File: tb/test_ow_bit_writer.sv
module test_ow_bit_writer;
    localparam int LOW_C  = 90;
    localparam int REL_C  = 990;
    localparam int SLOT_C = 1140;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] byte_cnt = '0;
    logic [15:0] data = '0;
    logic hold = 1'b0;
    logic drive_low, busy, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    ow_bit_writer i_ow_bit_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
        .data(data), .hold(hold), .drive_low(drive_low), .busy(busy), .done(done)
    );

    // behavioural reference: 0 idle, 1 slot, 2 paused, 3 finished
    int m_mode = 0;
    int m_cyc = 0;
    bit m_bits[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cyc = 0; m_bits.delete();
        end else begin
            case (m_mode)
                0, 3: begin
                    if (start) begin
                        int n;
                        n = (byte_cnt > 2) ? 2 : int'(byte_cnt);
                        m_bits.delete();
                        for (int i = 0; i < n * 8; i++) m_bits.push_back(data[i]);
                        m_mode = (n == 0) ? 3 : 1;
                        m_cyc = 0;
                    end else m_mode = 0;
                end
                1: begin
                    if (m_cyc == SLOT_C - 1) begin
                        void'(m_bits.pop_front());
                        if (m_bits.size() == 0) m_mode = 3;
                        else if (hold) m_mode = 2;
                        else m_cyc = 0;
                    end else m_cyc++;
                end
                2: if (!hold) begin m_mode = 1; m_cyc = 0; end
                default: m_mode = 0;
            endcase
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_drv, e_busy, e_done;
            string rq;
            e_drv = 0; e_busy = 0; e_done = 0; rq = "R1";
            case (m_mode)
                1: begin
                    e_busy = 1;
                    e_drv = (m_cyc < LOW_C) || (m_cyc < REL_C && !m_bits[0]);
                    rq = (m_cyc < LOW_C) ? "R3" : (m_cyc < REL_C) ? "R4" : "R5";
                end
                2: begin e_busy = 1; rq = "R7"; end
                3: begin e_done = 1; rq = "R9"; end
                default: rq = "R8";
            endcase
            check({rq, " drive_low"}, drive_low, e_drv);
            check("R8 busy", busy, e_busy);
            check("R9 done", done, e_done);
        end
    end

    // pulse-width monitor, independent of the reference
    int run_len = 0;
    int widths[$];
    always @(negedge clk) begin
        if (rst_n) begin
            if (drive_low) run_len++;
            else if (run_len > 0) begin widths.push_back(run_len); run_len = 0; end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic kick(input logic [1:0] nb, input logic [15:0] d);
        @(negedge clk);
        byte_cnt = nb; data = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic decode(input int nbits, input logic [15:0] d);
        logic [15:0] got;
        got = '0;
        check("R2 bit count", widths.size(), nbits);
        for (int i = 0; i < widths.size() && i < 16; i++) begin
            if (widths[i] != LOW_C && widths[i] != REL_C)
                check("R6 pulse width", widths[i], LOW_C);
            got[i] = (widths[i] == LOW_C);
        end
        if (nbits == 8) check("R2 value", int'(got[7:0]), int'(d[7:0]));
        else if (nbits == 16) check("R2 value", int'(got), int'(d));
        widths.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 drive_low", drive_low, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        rst_n = 1'b1;

        // one byte, mixed bits
        kick(2'd1, 16'h00A5);
        wait_done();
        decode(8, 16'h00A5);

        // two bytes
        kick(2'd2, 16'h3C96);
        wait_done();
        decode(16, 16'h3C96);

        // zero bytes: immediate done (R11)
        kick(2'd0, 16'hFFFF);
        check("R11 done after empty start", done, 1);
        @(negedge clk);
        check("R11 no slot", widths.size(), 0);

        // clamped byte count (R11) with start while busy (R10)
        kick(2'd3, 16'hBEEF);
        repeat (500) @(negedge clk);
        byte_cnt = 2'd1; data = 16'h0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 still busy", busy, 1);
        wait_done();
        decode(16, 16'hBEEF);

        // pause between bits (R7)
        kick(2'd1, 16'h005A);
        hold = 1'b1;
        repeat (SLOT_C + 400) @(negedge clk);
        check("R7 paused busy", busy, 1);
        check("R7 paused released", drive_low, 0);
        repeat (300) @(negedge clk);
        hold = 1'b0;
        wait_done();
        decode(8, 16'h005A);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule